// File: doc/BRIEF.md
# Shift-Register Hardware Stack

This block is a last-in first-out store of fixed-width words held in a chain of registers that shift in either direction. It keeps no address pointer: every stored word moves down one place for each word pushed and up one place for each word popped, so the two topmost words are always sitting in fixed registers and drive the outputs directly. An execution core typically places one instance for data, one for return addresses (whose top word serves as the program counter) and one for addresses.

In each cycle the core gives a pop count and a push count, each 0 to 2, plus up to two words to write. The pops are applied first and then the pushes, so an operation can take two operands and return one or two results in a single cycle. The outputs are the two top entries, registered and valid in the cycle after the update, together with empty, full and a sticky overflow flag. Spilling to or filling from memory is outside this block.

Top module: `shift_stack`

## Requirements
- R1: A synchronous reset clears every entry and the depth; after it, `empty`=1, `full`=0, `overflow`=0, and `top0`=`top1`=0.
- R2: A push count of 1 with pop count 0 makes `wr_word0` the new `top0` and the old `top0` the new `top1`, visible in the cycle after the clock edge.
- R3: A push count of 2 with pop count 0 makes `wr_word0` the new `top0` and `wr_word1` the new `top1`; the old `top0` moves to the third place.
- R4: A pop count of 1 or 2 with push count 0 moves every entry up by that many places; the old `top1` becomes `top0` after a single pop.
- R5: When both counts are nonzero in one cycle, the pops are applied first and the pushes second, so the net movement is push count minus pop count and the new words sit at the top.
- R6: A count input of value 3 behaves exactly as a count of 2, for both push and pop.
- R7: Popping more words than are stored leaves the depth at 0, and any place not holding a stored word reads as zero, so `top0` and `top1` are 0 while `empty` is 1.
- R8: `empty` is 1 exactly when the depth is 0 and `full` is 1 exactly when the depth equals `DEPTH` (17 by default).
- R9: If the depth after the pops plus the push count exceeds `DEPTH`, the bottom entries fall off, the depth stays at `DEPTH`, and `overflow` becomes 1 and stays 1 until reset.
- R10: Words pushed one at a time come back out in reverse order when popped one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pop_cnt | input | 2 | Words to remove this cycle (0..2, 3 acts as 2) |
| push_cnt | input | 2 | Words to add this cycle (0..2, 3 acts as 2) |
| wr_word0 | input | WIDTH | Word that becomes the top on any push |
| wr_word1 | input | WIDTH | Word that becomes second from top on a two-word push |
| top0 | output | WIDTH | Top entry |
| top1 | output | WIDTH | Second entry |
| empty | output | 1 | Depth is zero |
| full | output | 1 | Depth equals DEPTH |
| overflow | output | 1 | Sticky: a push has discarded a bottom entry |

## Verification
Pop and push can land in the same cycle, and a push on a full stack can coincide with the loss of a bottom entry; both collisions are the risky ones. The bench drives every pairing of pop and push counts, including the value 3, against stacks that are empty, one deep, partly filled and full, and a long random run keeps the depth swinging across both limits. A queue model in the bench removes and then inserts words each cycle and trims the tail past the capacity, and every cycle the two tops and the three flags are compared against it.

// File: rtl/shstk_pkg.sv
package shstk_pkg;
   // Word-move count for one port (0, 1 or 2; 3 saturates to 2)
   typedef logic [1:0] cnt_t;
   // Signed net movement, pop minus push, in two's complement
   typedef logic [2:0] shift_t;

   localparam shift_t SH_DN2  = 3'b110;  // two places toward the bottom
   localparam shift_t SH_DN1  = 3'b111;  // one place toward the bottom
   localparam shift_t SH_HOLD = 3'b000;
   localparam shift_t SH_UP1  = 3'b001;  // one place toward the top
   localparam shift_t SH_UP2  = 3'b010;  // two places toward the top

   function automatic cnt_t sat_cnt(input cnt_t c);
      return (c == 2'd3) ? 2'd2 : c;
   endfunction
endpackage

// File: rtl/shstk_cell.sv
module shstk_cell
   import shstk_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  shift_t           move,
   input  logic             load,
   input  logic [WIDTH-1:0] load_word,
   input  logic [WIDTH-1:0] from_above2,
   input  logic [WIDTH-1:0] from_above1,
   input  logic [WIDTH-1:0] from_below1,
   input  logic [WIDTH-1:0] from_below2,
   output logic [WIDTH-1:0] value
);
   logic [WIDTH-1:0] nxt;

   always_comb begin
      nxt = value;
      if (load) begin
         nxt = load_word;
      end else begin
         case (move)
            SH_DN2:  nxt = from_above2;
            SH_DN1:  nxt = from_above1;
            SH_UP1:  nxt = from_below1;
            SH_UP2:  nxt = from_below2;
            default: nxt = value;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) value <= '0;
      else     value <= nxt;
   end
endmodule

// File: rtl/shstk_depth.sv
module shstk_depth
   import shstk_pkg::*;
#(
   parameter int DEPTH = 17,
   localparam int DW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  cnt_t          pops,
   input  cnt_t          pushes,
   output logic [DW-1:0] depth,
   output logic          empty,
   output logic          full,
   output logic          overflow
);
   localparam logic [DW:0] LIMIT = DEPTH[DW:0];

   logic [DW-1:0] pops_w;
   logic [DW-1:0] after_pop;
   logic [DW:0]   sum;
   logic          spill;

   assign pops_w    = {{(DW-2){1'b0}}, pops};
   assign after_pop = (depth > pops_w) ? depth - pops_w : '0;
   assign sum       = {1'b0, after_pop} + {{(DW-1){1'b0}}, pushes};
   assign spill     = (sum > LIMIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         depth    <= '0;
         overflow <= 1'b0;
      end else begin
         depth <= spill ? LIMIT[DW-1:0] : sum[DW-1:0];
         if (spill) overflow <= 1'b1;
      end
   end

   assign empty = (depth == '0);
   assign full  = (depth == LIMIT[DW-1:0]);

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);  // R9
   AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (rst)
      $rose(overflow) |-> full);  // R9
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(empty && full));  // R8
   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
      {1'b0, depth} <= LIMIT);  // R8
endmodule

// File: rtl/shift_stack.sv
module shift_stack
   import shstk_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int DEPTH = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       pop_cnt,
   input  logic [1:0]       push_cnt,
   input  logic [WIDTH-1:0] wr_word0,
   input  logic [WIDTH-1:0] wr_word1,
   output logic [WIDTH-1:0] top0,
   output logic [WIDTH-1:0] top1,
   output logic             empty,
   output logic             full,
   output logic             overflow
);
   localparam int DW = $clog2(DEPTH + 1);

   if (WIDTH < 1) begin : g_bad_width
      $error("shift_stack: WIDTH must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("shift_stack: DEPTH must be at least 2");
   end

   cnt_t          p_eff;
   cnt_t          q_eff;
   shift_t        move;
   logic [DW-1:0] depth;
   logic [WIDTH-1:0] ent [DEPTH];

   assign p_eff = sat_cnt(pop_cnt);
   assign q_eff = sat_cnt(push_cnt);
   assign move  = {1'b0, p_eff} - {1'b0, q_eff};

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [WIDTH-1:0] a2, a1, b1, b2;
      logic             ld;
      logic [WIDTH-1:0] lw;

      if (i >= 2) begin : g_a2
         assign a2 = ent[i-2];
      end else begin : g_a2z
         assign a2 = '0;
      end
      if (i >= 1) begin : g_a1
         assign a1 = ent[i-1];
      end else begin : g_a1z
         assign a1 = '0;
      end
      if (i + 1 < DEPTH) begin : g_b1
         assign b1 = ent[i+1];
      end else begin : g_b1z
         assign b1 = '0;
      end
      if (i + 2 < DEPTH) begin : g_b2
         assign b2 = ent[i+2];
      end else begin : g_b2z
         assign b2 = '0;
      end

      if (i == 0) begin : g_ld0
         assign ld = (q_eff != 2'd0);
         assign lw = wr_word0;
      end else if (i == 1) begin : g_ld1
         assign ld = (q_eff == 2'd2);
         assign lw = wr_word1;
      end else begin : g_ldn
         assign ld = 1'b0;
         assign lw = '0;
      end

      shstk_cell #(.WIDTH(WIDTH)) u_cell (
         .clk        (clk),
         .rst        (rst),
         .move       (move),
         .load       (ld),
         .load_word  (lw),
         .from_above2(a2),
         .from_above1(a1),
         .from_below1(b1),
         .from_below2(b2),
         .value      (ent[i])
      );
   end

   shstk_depth #(.DEPTH(DEPTH)) u_depth (
      .clk     (clk),
      .rst     (rst),
      .pops    (p_eff),
      .pushes  (q_eff),
      .depth   (depth),
      .empty   (empty),
      .full    (full),
      .overflow(overflow)
   );

   assign top0 = ent[0];
   assign top1 = ent[1];

   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      empty |-> (top0 == '0 && top1 == '0));  // R7
   AST_PUSH_LANDS_TOP: assert property (@(posedge clk) disable iff (rst)
      (push_cnt != 2'd0) |=> (top0 == $past(wr_word0)));  // R2
   AST_PUSH2_SECOND: assert property (@(posedge clk) disable iff (rst)
      (push_cnt[1] && pop_cnt == 2'd0) |=> (top1 == $past(wr_word1)));  // R3
   AST_POP1_RISES: assert property (@(posedge clk) disable iff (rst)
      (pop_cnt == 2'd1 && push_cnt == 2'd0) |=> (top0 == $past(top1)));  // R4
   AST_PUSH1_DEMOTES: assert property (@(posedge clk) disable iff (rst)
      (push_cnt == 2'd1 && pop_cnt == 2'd0) |=> (top1 == $past(top0)));  // R2
endmodule

// File: tb/shift_stack_tb.sv
module shift_stack_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int D = 17;
   localparam int WATCHDOG = 150000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   pop_cnt = '0;
   logic [1:0]   push_cnt = '0;
   logic [W-1:0] wr_word0 = '0;
   logic [W-1:0] wr_word1 = '0;
   logic [W-1:0] top0, top1;
   logic         empty, full, overflow;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;

   logic [W-1:0] mq[$];
   bit           m_ovf = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shift_stack #(.WIDTH(W), .DEPTH(D)) u_dut (
      .clk(clk), .rst(rst), .pop_cnt(pop_cnt), .push_cnt(push_cnt),
      .wr_word0(wr_word0), .wr_word1(wr_word1),
      .top0(top0), .top1(top1), .empty(empty), .full(full), .overflow(overflow)
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WATCHDOG);
         summary();
         $finish;
      end
   end

   function automatic int sat(input logic [1:0] c);
      return (c == 2'd3) ? 2 : int'(c);
   endfunction

   task automatic model_step(input logic [1:0] p, input logic [1:0] q,
                             input logic [W-1:0] w0, input logic [W-1:0] w1);
      for (int k = 0; k < sat(p); k++) if (mq.size() > 0) void'(mq.pop_front());
      if (sat(q) == 2) mq.push_front(w1);
      if (sat(q) >= 1) mq.push_front(w0);
      while (mq.size() > D) begin
         void'(mq.pop_back());
         m_ovf = 1;
      end
   endtask

   task automatic compare(input string tag);
      logic [W-1:0] e0, e1;
      logic ee, ef;
      e0 = (mq.size() > 0) ? mq[0] : '0;
      e1 = (mq.size() > 1) ? mq[1] : '0;
      ee = (mq.size() == 0);
      ef = (mq.size() == D);
      vectors++;
      if (top0 !== e0) begin
         fails++; $display("FAIL %s top0: actual %h expected %h", tag, top0, e0);
      end
      if (top1 !== e1) begin
         fails++; $display("FAIL %s top1: actual %h expected %h", tag, top1, e1);
      end
      if (empty !== ee) begin
         fails++; $display("FAIL %s empty: actual %b expected %b", tag, empty, ee);
      end
      if (full !== ef) begin
         fails++; $display("FAIL %s full: actual %b expected %b", tag, full, ef);
      end
      if (overflow !== m_ovf) begin
         fails++; $display("FAIL %s overflow: actual %b expected %b", tag, overflow, m_ovf);
      end
   endtask

   // Called at a falling edge: drive, let the rising edge update, check at next falling edge.
   task automatic step(input logic [1:0] p, input logic [1:0] q,
                       input logic [W-1:0] w0, input logic [W-1:0] w1, input string tag);
      pop_cnt = p; push_cnt = q; wr_word0 = w0; wr_word1 = w1;
      @(posedge clk);
      model_step(p, q, w0, w1);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      pop_cnt = '0; push_cnt = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      mq.delete();
      m_ovf = 0;
      compare("R1 reset");
   endtask

   initial begin
      do_reset();

      // R7: pops on an empty stack
      step(2'd1, 2'd0, 32'h1, 32'h2, "R7 pop1 empty");
      step(2'd2, 2'd0, 32'h1, 32'h2, "R7 pop2 empty");

      // R2: single pushes
      step(2'd0, 2'd1, 32'hA000_0001, 32'hDEAD_0000, "R2 push1");
      step(2'd0, 2'd1, 32'hA000_0002, 32'hDEAD_0000, "R2 push1 demote");
      // R3: double push
      step(2'd0, 2'd2, 32'hB000_0001, 32'hB000_0002, "R3 push2");
      // R4: pops
      step(2'd1, 2'd0, '0, '0, "R4 pop1");
      step(2'd2, 2'd0, '0, '0, "R4 pop2");
      // R7: pop two with one left
      step(2'd2, 2'd0, '0, '0, "R7 overpop");
      // R5: combined pop and push
      step(2'd0, 2'd2, 32'hC1, 32'hC2, "R5 prefill");
      step(2'd0, 2'd2, 32'hC3, 32'hC4, "R5 prefill");
      step(2'd2, 2'd1, 32'hC5, 32'hC6, "R5 pop2 push1");
      step(2'd1, 2'd2, 32'hC7, 32'hC8, "R5 pop1 push2");
      step(2'd1, 2'd1, 32'hC9, 32'hCA, "R5 replace");
      step(2'd2, 2'd2, 32'hCB, 32'hCC, "R5 pop2 push2");
      // R6: count value 3
      step(2'd0, 2'd3, 32'hD1, 32'hD2, "R6 push3");
      step(2'd3, 2'd0, '0, '0, "R6 pop3");
      step(2'd3, 2'd3, 32'hD3, 32'hD4, "R6 both3");

      // R10: LIFO order with single pushes then pops
      do_reset();
      for (int i = 0; i < 10; i++) step(2'd0, 2'd1, 32'hE000_0000 + i, '0, "R10 fill");
      for (int i = 0; i < 11; i++) step(2'd1, 2'd0, '0, '0, "R10 drain");

      // R8: fill exactly to full, R9: overflow
      for (int i = 0; i < 8; i++) step(2'd0, 2'd2, 32'hF000_0000 + 2*i, 32'hF000_0001 + 2*i, "R8 fill");
      step(2'd0, 2'd1, 32'hF0FF_FFFF, '0, "R8 reach full");
      step(2'd1, 2'd1, 32'h1234_5678, '0, "R8 replace at full");
      step(2'd0, 2'd1, 32'h0BAD_0001, '0, "R9 push over full");
      step(2'd0, 2'd2, 32'h0BAD_0002, 32'h0BAD_0003, "R9 push2 over full");
      for (int i = 0; i < D + 2; i++) step(2'd1, 2'd0, '0, '0, "R9 drain sticky");
      step(2'd0, 2'd1, 32'h5, '0, "R9 sticky after drain");
      do_reset();

      // R5: random mix across both limits
      for (int i = 0; i < 3000; i++) begin
         step(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
              $urandom(), $urandom(), "R5 random");
         if (i == 1500) do_reset();
      end

      done = 1;
      summary();
      $finish;
   end
endmodule